// File: doc/BRIEF.md
# Execution-Context Memory Access Guard

This block sits on the instruction-fetch and data buses of a small processor core. It follows which execution context the core is in: trusted firmware, untrusted application, the high-priority system-call handler or the low-priority system-call handler. From that context it decides whether the protected firmware RAM may be touched. When access is denied, the RAM select and write strobe are held low and the read data returned to the core is forced to zero.

The block also turns stores to two fixed trigger addresses into one-cycle interrupt request pulses, one for each system-call priority. It raises a trap flag when application code tries to fetch an instruction from firmware space.

The context only moves from firmware to application when an instruction is fetched from application RAM. A plain jump back into firmware space never restores firmware privilege. It only raises the trap. The high-priority handler is trusted even when it interrupts application code. The low-priority handler is not.

Top module: `exec_ctx_guard`

## Requirements
- R1: After a synchronous active-low reset, `ctx_state` is 0 (firmware), `fetch_trap` is low, and both interrupt request outputs are low.
- R2: In firmware context (`ctx_state`=0), a bus access inside the protected window (base 0xD000_0000, 4 KiB) drives `fw_ram_en` high and `fw_ram_we` equal to `bus_write`. `fw_rdata` equals `ram_rdata` in the same cycle.
- R3: In firmware context, a valid fetch inside application RAM (base 0x4000_0000, 64 KiB) moves `ctx_state` to 1 (application) on the next clock edge.
- R4: In application context, a protected-window access keeps `fw_ram_en` and `fw_ram_we` low, and `fw_rdata` reads as zero.
- R5: A valid bus write to the word at 0xE100_0000 makes `irq_hi_req` high for exactly the one cycle after the write edge. Address bits [1:0] and the write data are ignored.
- R6: A valid bus write to the word at 0xE000_0000 makes `irq_lo_req` high for exactly the one cycle after the write edge.
- R7: `irq_enter` outside any handler moves `ctx_state` to 2 (high syscall) when `irq_hi_pend` is set, whether or not `irq_lo_pend` is also set. In this state protected access is granted as in R2, also when the handler was entered from application context. `irq_enter` while a handler is active is ignored.
- R8: `irq_enter` with only `irq_lo_pend` set moves `ctx_state` to 3 (low syscall). In this state protected access is denied as in R4.
- R9: `irq_return` inside a handler restores `ctx_state` to the value it had before entry: 0 or 1.
- R10: `fetch_trap` is high in the same cycle as a valid fetch inside firmware space (0x0000_0000, 64 KiB) while `ctx_state` is 1. The flag stays low for such fetches in the firmware context and in both handler contexts.
- R11: A fetch from firmware space in application context leaves `ctx_state` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_addr | input | 32 | Instruction fetch address |
| bus_valid | input | 1 | Data bus access in progress |
| bus_write | input | 1 | Data access is a write |
| bus_addr | input | 32 | Data access address |
| ram_rdata | input | 32 | Read data from the protected RAM |
| irq_enter | input | 1 | Core enters its interrupt handler this cycle |
| irq_hi_pend | input | 1 | High-priority syscall is among the sources being serviced |
| irq_lo_pend | input | 1 | Low-priority syscall is among the sources being serviced |
| irq_return | input | 1 | Core returns from its interrupt handler this cycle |
| fw_ram_en | output | 1 | Select for the protected RAM |
| fw_ram_we | output | 1 | Write strobe for the protected RAM |
| fw_rdata | output | 32 | Gated protected-RAM read data to the core |
| fetch_trap | output | 1 | Illegal fetch from firmware space by application code |
| irq_hi_req | output | 1 | High-priority syscall request pulse |
| irq_lo_req | output | 1 | Low-priority syscall request pulse |
| ctx_state | output | 2 | Current context: 0 firmware, 1 application, 2 high syscall, 3 low syscall |

## Verification
The bench follows the same path a real system takes: firmware writes, hand-off to the application, both trigger stores, and entry into and return from each handler. It checks gating at every step. The key corner is the high-priority handler entered from application code. A guard that keys access to a single firmware bit would return zero there, and one that trusts every handler would leak data in the low-priority handler. The bench also checks that returning from a handler restores the saved mode and does not fall back to firmware, that a fetch back into firmware space traps without raising privilege, that a nested entry is ignored, that the high source wins when both are pending, and that a trigger pulse lasts exactly one cycle even when the store address has nonzero low bits.

// File: rtl/ecg_pkg.sv
// Shared types for the execution-context guard.
// Assumes a single-issue core that reports handler entry and return as
// one-cycle strobes.
package ecg_pkg;

    typedef enum logic [1:0] {
        CTX_FW     = 2'd0,
        CTX_APP    = 2'd1,
        CTX_SYS_HI = 2'd2,
        CTX_SYS_LO = 2'd3
    } ctx_e;

endpackage

// File: rtl/ecg_region_match.sv
// Compares an address against an aligned power-of-two window.
// Assumes BASE is aligned to 2**AW bytes; the low AW address bits are
// masked out of the comparison.
module ecg_region_match #(
    parameter int                ADDR_W = 32,
    parameter int                AW     = 12,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << AW) - ADDR_W'(1));

    // Match on the bits above the window size.
    always_comb begin
        hit = (((addr ^ BASE) & HI_MASK) == '0);
    end
endmodule

// File: rtl/ecg_ctx_track.sv
// Holds the current execution context and the mode saved on handler entry.
// Assumes handlers do not nest: an entry strobe inside a handler is dropped.
// Priority within one cycle: entry, then return, then the fetch-driven switch.
module ecg_ctx_track
    import ecg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_app,
    input  logic irq_enter,
    input  logic irq_hi_pend,
    input  logic irq_return,
    output ctx_e ctx
);
    logic saved_app;
    logic in_handler;

    // Flag the two handler contexts.
    always_comb begin
        in_handler = (ctx == CTX_SYS_HI) || (ctx == CTX_SYS_LO);
    end

    // Advance the context on entry, return or first application fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx       <= CTX_FW;
            saved_app <= 1'b0;
        end else if (irq_enter && !in_handler) begin
            saved_app <= (ctx == CTX_APP);
            ctx       <= irq_hi_pend ? CTX_SYS_HI : CTX_SYS_LO;
        end else if (irq_return && in_handler) begin
            ctx <= saved_app ? CTX_APP : CTX_FW;
        end else if (ctx == CTX_FW && fetch_app) begin
            ctx <= CTX_APP;
        end
    end
endmodule

// File: rtl/ecg_irq_trigger.sv
// Turns stores to the syscall trigger words into one-cycle request pulses.
// Assumes at most one store per cycle per lane; lanes are independent.
module ecg_irq_trigger #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] store_hit,
    output logic [LANES-1:0] req
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register each lane's trigger for a single-cycle pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) req[g] <= 1'b0;
            else        req[g] <= store_hit[g];
        end
    end
endmodule

// File: rtl/exec_ctx_guard.sv
// Gates the protected firmware RAM by execution context, decodes the
// syscall trigger stores and flags illegal firmware fetches from
// application code. Assumes the RAM returns read data in the same cycle
// as the select, and that fetch and data buses are observed every cycle.
module exec_ctx_guard
    import ecg_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] PROT_BASE    = 32'hD000_0000,
    parameter int                PROT_AW      = 12,
    parameter logic [ADDR_W-1:0] APP_BASE     = 32'h4000_0000,
    parameter int                APP_AW       = 16,
    parameter logic [ADDR_W-1:0] FWSPACE_BASE = 32'h0000_0000,
    parameter int                FWSPACE_AW   = 16,
    parameter logic [ADDR_W-1:0] TRIG_HI_ADDR = 32'hE100_0000,
    parameter logic [ADDR_W-1:0] TRIG_LO_ADDR = 32'hE000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              irq_enter,
    input  logic              irq_hi_pend,
    input  logic              irq_lo_pend,
    input  logic              irq_return,
    output logic              fw_ram_en,
    output logic              fw_ram_we,
    output logic [DATA_W-1:0] fw_rdata,
    output logic              fetch_trap,
    output logic              irq_hi_req,
    output logic              irq_lo_req,
    output logic [1:0]        ctx_state
);
    localparam int WORD_AW = $clog2(DATA_W / 8);
    localparam int N_TRIG  = 2;

    logic hit_prot, hit_app, hit_fws, hit_thi, hit_tlo;
    logic access_ok;
    logic [N_TRIG-1:0] trig_store, trig_req;
    ctx_e ctx;

    ecg_region_match #(.ADDR_W(ADDR_W), .AW(PROT_AW),    .BASE(PROT_BASE))
        u_m_prot (.addr(bus_addr),   .hit(hit_prot));
    ecg_region_match #(.ADDR_W(ADDR_W), .AW(APP_AW),     .BASE(APP_BASE))
        u_m_app  (.addr(fetch_addr), .hit(hit_app));
    ecg_region_match #(.ADDR_W(ADDR_W), .AW(FWSPACE_AW), .BASE(FWSPACE_BASE))
        u_m_fws  (.addr(fetch_addr), .hit(hit_fws));
    ecg_region_match #(.ADDR_W(ADDR_W), .AW(WORD_AW),    .BASE(TRIG_HI_ADDR))
        u_m_thi  (.addr(bus_addr),   .hit(hit_thi));
    ecg_region_match #(.ADDR_W(ADDR_W), .AW(WORD_AW),    .BASE(TRIG_LO_ADDR))
        u_m_tlo  (.addr(bus_addr),   .hit(hit_tlo));

    ecg_ctx_track u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_app   (fetch_valid && hit_app),
        .irq_enter   (irq_enter),
        .irq_hi_pend (irq_hi_pend),
        .irq_return  (irq_return),
        .ctx         (ctx)
    );

    // Lane 1 is the high-priority trigger, lane 0 the low-priority one.
    always_comb begin
        trig_store = {bus_valid && bus_write && hit_thi,
                      bus_valid && bus_write && hit_tlo};
    end

    ecg_irq_trigger #(.LANES(N_TRIG)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_hit (trig_store),
        .req       (trig_req)
    );

    // Grant protected access in firmware and in the high syscall handler.
    always_comb begin
        access_ok = (ctx == CTX_FW) || (ctx == CTX_SYS_HI);
    end

    // Drive RAM strobes and the gated read path.
    always_comb begin
        fw_ram_en = bus_valid && hit_prot && access_ok;
        fw_ram_we = fw_ram_en && bus_write;
        fw_rdata  = fw_ram_en ? ram_rdata : '0;
    end

    // Flag firmware-space fetches from application code; export the state.
    always_comb begin
        fetch_trap = fetch_valid && hit_fws && (ctx == CTX_APP);
        irq_hi_req = trig_req[1];
        irq_lo_req = trig_req[0];
        ctx_state  = ctx;
    end

    // The low-priority pending bit only matters by its absence on entry.
    logic unused_lo;
    always_comb unused_lo = irq_lo_pend;
endmodule

// File: rtl/ecg_guard_checker.sv
// Concurrent checks on the guard's ports, attached by bind.
module ecg_guard_checker #(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] APP_BASE     = 32'h4000_0000,
    parameter int                APP_AW       = 16,
    parameter logic [ADDR_W-1:0] TRIG_HI_ADDR = 32'hE100_0000,
    parameter logic [ADDR_W-1:0] TRIG_LO_ADDR = 32'hE000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_enter,
    input logic              irq_return,
    input logic              fw_ram_en,
    input logic              fw_ram_we,
    input logic [DATA_W-1:0] fw_rdata,
    input logic              fetch_trap,
    input logic              irq_hi_req,
    input logic              irq_lo_req,
    input logic [1:0]        ctx_state
);
    localparam logic [ADDR_W-1:0] WMASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] AMASK = ~((ADDR_W'(1) << APP_AW) - ADDR_W'(1));

    logic st_hi, st_lo, app_fetch;
    always_comb begin
        st_hi     = bus_valid && bus_write && ((bus_addr & WMASK) == TRIG_HI_ADDR);
        st_lo     = bus_valid && bus_write && ((bus_addr & WMASK) == TRIG_LO_ADDR);
        app_fetch = fetch_valid && ((fetch_addr & AMASK) == APP_BASE);
    end

    a_r4_app_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_state == 2'd1 |-> !fw_ram_en && !fw_ram_we && fw_rdata == '0);
    a_r8_lo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_state == 2'd3 |-> !fw_ram_en && fw_rdata == '0);
    a_r3_enter_app: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_state == 2'd0 && app_fetch && !irq_enter && !irq_return |=> ctx_state == 2'd1);
    a_r5_hi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_hi |=> irq_hi_req);
    a_r5_hi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi_req |-> $past(st_hi));
    a_r6_lo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_lo |=> irq_lo_req);
    a_r10_trap_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_trap |-> ctx_state == 2'd1);
    a_r11_no_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_state == 2'd1 && !irq_enter |=> ctx_state == 2'd1);
    a_r9_return_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_state[1] && irq_return && !irq_enter |=> !ctx_state[1]);
endmodule

bind exec_ctx_guard ecg_guard_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .APP_BASE(APP_BASE), .APP_AW(APP_AW),
    .TRIG_HI_ADDR(TRIG_HI_ADDR), .TRIG_LO_ADDR(TRIG_LO_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .irq_enter(irq_enter), .irq_return(irq_return), .fw_ram_en(fw_ram_en),
    .fw_ram_we(fw_ram_we), .fw_rdata(fw_rdata), .fetch_trap(fetch_trap),
    .irq_hi_req(irq_hi_req), .irq_lo_req(irq_lo_req), .ctx_state(ctx_state)
);

// File: tb/exec_ctx_guard_tb.sv
`timescale 1ns/100ps
module exec_ctx_guard_tb;
    localparam logic [31:0] A_PROT = 32'hD000_0000;
    localparam logic [31:0] A_APP  = 32'h4000_0000;
    localparam logic [31:0] A_VEC  = 32'h0000_0010;
    localparam logic [31:0] A_THI  = 32'hE100_0000;
    localparam logic [31:0] A_TLO  = 32'hE000_0000;
    localparam logic [31:0] RAMVAL = 32'h5555_AAAA;

    typedef struct packed {
        logic fv; logic [31:0] fa;
        logic bv; logic bw; logic [31:0] ba;
        logic ie; logic ph; logic pl; logic ir;
        logic [1:0] x_ctx; logic x_en; logic x_we; logic x_rd;
        logic x_trap; logic x_hi; logic x_lo;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 24;
    // x_ctx is the context during the vector; x_hi/x_lo are sampled after its edge.
    localparam vec_t VECS [NV] = '{
        '{1'b0,32'h0,    1'b1,1'b0,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 4'd2},  // R2 read
        '{1'b0,32'h0,    1'b1,1'b1,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd2},  // R2 write
        '{1'b1,A_VEC,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10 no trap in fw
        '{1'b1,A_APP,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 app fetch
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 now app
        '{1'b0,32'h0,    1'b1,1'b0,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 read zero
        '{1'b0,32'h0,    1'b1,1'b1,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 write blocked
        '{1'b1,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 4'd10}, // R10 trap
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd11}, // R11 still app
        '{1'b0,32'h0,    1'b1,1'b1,A_THI,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd5},  // R5 pulse
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 single
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b1,1'b1,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 enter hi
        '{1'b0,32'h0,    1'b1,1'b0,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 4'd7},  // R7 access
        '{1'b1,A_VEC,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10 handler fetch
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b1, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9 return
        '{1'b0,32'h0,    1'b1,1'b0,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9 back in app
        '{1'b0,32'h0,    1'b1,1'b1,A_TLO,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 pulse
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b1,1'b0,1'b1,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8 enter lo
        '{1'b0,32'h0,    1'b1,1'b0,A_PROT, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8 blocked
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b1,1'b1,1'b0,1'b0, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 nested ignored
        '{1'b0,32'h0,    1'b1,1'b1,A_PROT, 1'b0,1'b0,1'b0,1'b1, 2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8 write blocked
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b1,1'b1,1'b1,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 hi wins
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b1, 2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 in hi
        '{1'b0,32'h0,    1'b0,1'b0,32'h0,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9}   // R9 app again
    };

    logic clk = 1'b0;
    logic rst_n;
    logic fetch_valid, bus_valid, bus_write, irq_enter, irq_hi_pend, irq_lo_pend, irq_return;
    logic [31:0] fetch_addr, bus_addr, ram_rdata, fw_rdata;
    logic fw_ram_en, fw_ram_we, fetch_trap, irq_hi_req, irq_lo_req;
    logic [1:0] ctx_state;
    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    exec_ctx_guard u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .ram_rdata(ram_rdata), .irq_enter(irq_enter), .irq_hi_pend(irq_hi_pend),
        .irq_lo_pend(irq_lo_pend), .irq_return(irq_return), .fw_ram_en(fw_ram_en),
        .fw_ram_we(fw_ram_we), .fw_rdata(fw_rdata), .fetch_trap(fetch_trap),
        .irq_hi_req(irq_hi_req), .irq_lo_req(irq_lo_req), .ctx_state(ctx_state)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid = 0; fetch_addr = '0; bus_valid = 0; bus_write = 0; bus_addr = '0;
        irq_enter = 0; irq_hi_pend = 0; irq_lo_pend = 0; irq_return = 0;
    endtask

    task automatic apply(input vec_t v);
        fetch_valid = v.fv; fetch_addr = v.fa; bus_valid = v.bv; bus_write = v.bw;
        bus_addr = v.ba; irq_enter = v.ie; irq_hi_pend = v.ph; irq_lo_pend = v.pl;
        irq_return = v.ir;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
    endtask

    initial begin
        ram_rdata = RAMVAL;
        idle();
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        #1;
        chk("R1", "ctx", 32'(ctx_state), 32'd0);
        chk("R1", "trap", 32'(fetch_trap), 32'd0);
        chk("R1", "hi", 32'(irq_hi_req), 32'd0);
        chk("R1", "lo", 32'(irq_lo_req), 32'd0);
        @(negedge clk); rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            apply(VECS[i]);
            tag = $sformatf("R%0d v%0d", VECS[i].rq, i);
            #1;
            chk(tag, "ctx", 32'(ctx_state), 32'(VECS[i].x_ctx));
            chk(tag, "en", 32'(fw_ram_en), 32'(VECS[i].x_en));
            chk(tag, "we", 32'(fw_ram_we), 32'(VECS[i].x_we));
            chk(tag, "rdata", fw_rdata, VECS[i].x_rd ? RAMVAL : 32'h0);
            chk(tag, "trap", 32'(fetch_trap), 32'(VECS[i].x_trap));
            @(posedge clk); #1;
            chk(tag, "hi", 32'(irq_hi_req), 32'(VECS[i].x_hi));
            chk(tag, "lo", 32'(irq_lo_req), 32'(VECS[i].x_lo));
        end

        // R1: reset from application context returns to firmware
        do_reset();
        #1;
        chk("R1", "ctx after reset", 32'(ctx_state), 32'd0);

        // R9: handler entered from firmware returns to firmware
        @(negedge clk); idle(); irq_enter = 1; irq_hi_pend = 1;
        @(negedge clk); idle(); irq_return = 1;
        #1; chk("R9", "ctx in hi", 32'(ctx_state), 32'd2);
        @(negedge clk); idle();
        #1; chk("R9", "ctx fw restored", 32'(ctx_state), 32'd0);

        // R5: low address bits ignored, single-cycle pulse
        @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = A_THI | 32'h2;
        @(posedge clk); #1; chk("R5", "hi offset", 32'(irq_hi_req), 32'd1);
        @(negedge clk); idle();
        @(posedge clk); #1; chk("R5", "hi cleared", 32'(irq_hi_req), 32'd0);

        // R5: read of the trigger word raises nothing
        @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = A_THI;
        @(posedge clk); #1; chk("R5", "read no pulse", 32'(irq_hi_req), 32'd0);

        // R2: just outside the protected window is not selected
        @(negedge clk); idle(); bus_valid = 1; bus_addr = A_PROT + 32'h1000;
        #1; chk("R2", "outside window", 32'(fw_ram_en), 32'd0);

        // R11: a firmware-space fetch does not restore privilege
        @(negedge clk); idle(); fetch_valid = 1; fetch_addr = A_APP + 32'h20;
        @(negedge clk); idle(); fetch_valid = 1; fetch_addr = 32'h0;
        #1; chk("R10", "trap at 0", 32'(fetch_trap), 32'd1);
        @(negedge clk); idle(); bus_valid = 1; bus_addr = A_PROT;
        #1; chk("R11", "ctx stays app", 32'(ctx_state), 32'd1);
        chk("R11", "still blocked", fw_rdata, 32'h0);

        @(negedge clk); idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule